// File: doc/BRIEF.md
# LFSR Trajectory Self-Test Checker

This block judges a buffer of 64-bit words captured from a random source that was placed in a diagnostic mode. In that mode a healthy source produces words that lie on a known linear-feedback trajectory. The checker holds the captured words in its own storage, loaded one word at a time over a valid/ready write port. On a start pulse it takes one of two seed constants as its first candidate. It then makes repeated passes over the buffer. Each pass compares the current candidate against every stored word except the one at index 0, and the matches are added to a running total. Between passes the candidate is stepped once along the Galois LFSR trajectory.

The check ends with pass as soon as the running total reaches the match goal at the end of a pass. It ends with fail when the allowed number of passes has run without reaching the goal. The outcome stays on done/pass/fail until the next accepted start. The write port applies back-pressure: ld_ready is low for the whole of a check. A word offered during a check is not taken and stays pending at the source until ld_ready rises again.

Top module: `seqchk_top`

## Requirements
- R1: After reset, done, pass and fail are 0 and ld_ready is 1.
- R2: A word is written to slot ld_index when ld_valid and ld_ready are both 1 at a clock edge. ld_ready is 0 from the cycle after an accepted start until done rises. A word offered while ld_ready is 0 is not stored and has no effect on the result.
- R3: Between passes the candidate steps once: it shifts left by one bit, and if the old bit 63 was 1 the result is XORed with parameter POLY.
- R4: The word in slot 0 is never compared. Each pass compares slots 1 to DEPTH-1, one slot per cycle, so a pass lasts DEPTH-1 cycles.
- R5: The match total accumulates across passes and is not cleared between them.
- R6: At the end of each pass, if the total is at or above MATCH_GOAL, the check ends with pass=1. This test is made before the candidate is stepped. done rises exactly P*(DEPTH-1) cycles after the start edge, where P is the number of passes made.
- R7: If MAX_LOOPS passes complete without reaching the goal, the check ends with fail=1, MAX_LOOPS*(DEPTH-1) cycles after the start edge.
- R8: seed_sel is sampled at the start edge. A value of 0 selects SEED_A as the first candidate, and 1 selects SEED_B.
- R9: done, pass and fail hold their values until the next accepted start, which clears all three. A start pulse while a check runs is ignored.
- R10: pass and fail are never both 1, and either one is 1 exactly when done is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a check (accepted when ld_ready is 1) |
| seed_sel | input | 1 | Seed choice sampled at start |
| ld_valid | input | 1 | Buffer write offered |
| ld_ready | output | 1 | Buffer write can be taken (no check running) |
| ld_index | input | $clog2(DEPTH) | Buffer slot to write |
| ld_data | input | WORD_W | Word to write |
| done | output | 1 | Check finished, result valid |
| pass | output | 1 | Goal reached |
| fail | output | 1 | Pass limit hit without reaching the goal |

## Verification
Most internal faults show up as a wrong time of completion, because the time of completion shows how many passes were made. A miscounted index, a lost accumulation or a wrong candidate step moves the rise of done by a whole pass of DEPTH-1 cycles, or turns pass into fail. The bench therefore checks the exact latency as well as the outcome of every check. If slot 0 were compared, or if a write were taken while a check runs, the check would end on an earlier pass than expected. Stimulus buffers are built from the trajectory with the hits placed on known passes.

// File: rtl/seqchk_pkg.sv
package seqchk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } seqchk_state_e;

  typedef enum logic [1:0] {
    RES_NONE = 2'd0,
    RES_PASS = 2'd1,
    RES_FAIL = 2'd2
  } seqchk_result_e;

endpackage

// File: rtl/seqchk_store.sv
module seqchk_store #(
  parameter int DEPTH  = 8,
  parameter int WORD_W = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_data
);

  logic [WORD_W-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (sel) slot_q[g] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_idx == IDX_W'(i)) rd_data = slot_q[i];
    end
  end

endmodule

// File: rtl/seqchk_cand.sv
module seqchk_cand #(
  parameter int                WORD_W = 64,
  parameter logic [WORD_W-1:0] POLY   = 64'h42F0E1EBA9EA3693,
  parameter logic [WORD_W-1:0] SEED_A = 64'h0123456789ABCDEF,
  parameter logic [WORD_W-1:0] SEED_B = 64'hF1E2D3C4B5A69788
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              seed_sel,
  input  logic              adv,
  output logic [WORD_W-1:0] cand
);

  logic [WORD_W-1:0] cand_q;
  logic [WORD_W-1:0] stepped;
  logic [WORD_W-1:0] shifted;

  // Galois step: shift towards the top, fold the poly in when the top bit leaves
  assign shifted = {cand_q[WORD_W-2:0], 1'b0};
  assign stepped = cand_q[WORD_W-1] ? (shifted ^ POLY) : shifted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q <= '0;
    end else if (load) begin
      cand_q <= seed_sel ? SEED_B : SEED_A;
    end else if (adv) begin
      cand_q <= stepped;
    end
  end

  assign cand = cand_q;

endmodule

// File: rtl/seqchk_ctrl.sv
module seqchk_ctrl
  import seqchk_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int MATCH_GOAL = 3,
  parameter int MAX_LOOPS  = 6,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int LOOP_W = $clog2(MAX_LOOPS + 1),
  localparam int ACC_W  = $clog2(MATCH_GOAL + DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             hit,
  output logic             busy,
  output logic [IDX_W-1:0] rd_idx,
  output logic             load_seed,
  output logic             adv,
  output logic             done,
  output logic             pass,
  output logic             fail
);

  localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(DEPTH - 1);
  localparam logic [IDX_W-1:0]  FIRST_IDX = IDX_W'(1);
  localparam logic [ACC_W-1:0]  GOAL      = ACC_W'(MATCH_GOAL);
  localparam logic [LOOP_W-1:0] LAST_LOOP = LOOP_W'(MAX_LOOPS - 1);

  seqchk_state_e     state_q;
  seqchk_result_e    res_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ACC_W-1:0]  acc_q;
  logic [LOOP_W-1:0] loops_q;

  logic             start_acc;
  logic             running;
  logic [ACC_W-1:0] acc_next;
  logic             pass_end;
  logic             goal_met;
  logic             last_loop;

  assign running   = (state_q == ST_RUN);
  assign start_acc = start && !running;
  assign acc_next  = acc_q + ACC_W'(hit);
  assign pass_end  = running && (idx_q == LAST_IDX);
  assign goal_met  = (acc_next >= GOAL);
  assign last_loop = (loops_q == LAST_LOOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      res_q   <= RES_NONE;
      idx_q   <= FIRST_IDX;
      acc_q   <= '0;
      loops_q <= '0;
    end else if (start_acc) begin
      state_q <= ST_RUN;
      res_q   <= RES_NONE;
      idx_q   <= FIRST_IDX;
      acc_q   <= '0;
      loops_q <= '0;
    end else if (running) begin
      acc_q <= acc_next;
      if (!pass_end) begin
        idx_q <= idx_q + IDX_W'(1);
      end else if (goal_met) begin
        state_q <= ST_DONE;
        res_q   <= RES_PASS;
      end else if (last_loop) begin
        state_q <= ST_DONE;
        res_q   <= RES_FAIL;
      end else begin
        idx_q   <= FIRST_IDX;
        loops_q <= loops_q + LOOP_W'(1);
      end
    end
  end

  assign busy      = running;
  assign rd_idx    = idx_q;
  assign load_seed = start_acc;
  assign adv       = pass_end && !goal_met && !last_loop;
  assign done      = (state_q == ST_DONE);
  assign pass      = (res_q == RES_PASS);
  assign fail      = (res_q == RES_FAIL);

endmodule

// File: rtl/seqchk_top.sv
module seqchk_top #(
  parameter int                DEPTH      = 8,
  parameter int                WORD_W     = 64,
  parameter int                MATCH_GOAL = 3,
  parameter int                MAX_LOOPS  = 6,
  parameter logic [WORD_W-1:0] POLY       = 64'h42F0E1EBA9EA3693,
  parameter logic [WORD_W-1:0] SEED_A     = 64'h0123456789ABCDEF,
  parameter logic [WORD_W-1:0] SEED_B     = 64'hF1E2D3C4B5A69788,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              seed_sel,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [IDX_W-1:0]  ld_index,
  input  logic [WORD_W-1:0] ld_data,
  output logic              done,
  output logic              pass,
  output logic              fail
);

  logic              busy;
  logic [IDX_W-1:0]  rd_idx;
  logic [WORD_W-1:0] rd_word;
  logic [WORD_W-1:0] cand;
  logic              load_seed;
  logic              adv;
  logic              hit;

  assign ld_ready = !busy;
  assign hit      = (rd_word == cand);

  seqchk_store #(
    .DEPTH  (DEPTH),
    .WORD_W (WORD_W)
  ) store_i (
    .clk     (clk),
    .wr_en   (ld_valid && ld_ready),
    .wr_idx  (ld_index),
    .wr_data (ld_data),
    .rd_idx  (rd_idx),
    .rd_data (rd_word)
  );

  seqchk_cand #(
    .WORD_W (WORD_W),
    .POLY   (POLY),
    .SEED_A (SEED_A),
    .SEED_B (SEED_B)
  ) cand_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_seed),
    .seed_sel (seed_sel),
    .adv      (adv),
    .cand     (cand)
  );

  seqchk_ctrl #(
    .DEPTH      (DEPTH),
    .MATCH_GOAL (MATCH_GOAL),
    .MAX_LOOPS  (MAX_LOOPS)
  ) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .hit       (hit),
    .busy      (busy),
    .rd_idx    (rd_idx),
    .load_seed (load_seed),
    .adv       (adv),
    .done      (done),
    .pass      (pass),
    .fail      (fail)
  );

endmodule

// File: rtl/seqchk_chk.sv
module seqchk_chk #(
  parameter int DEPTH     = 8,
  parameter int MAX_LOOPS = 6
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic ld_ready,
  input logic done,
  input logic pass,
  input logic fail
);

  localparam int PASS_CYC = DEPTH - 1;

  int unsigned run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_cnt <= 0;
    else if (start && ld_ready) run_cnt <= 0;
    else if (!ld_ready) run_cnt <= run_cnt + 1;
  end

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass && fail));

  a_r10_flag_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    done == (pass || fail));

  a_r2_ready_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ld_ready);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(pass) && $stable(fail)));

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ld_ready) |=> (!done && !ld_ready));

  a_r6_pass_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ((run_cnt % PASS_CYC) == 0 && run_cnt != 0));

  a_r7_fail_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> (run_cnt == MAX_LOOPS * PASS_CYC));

endmodule

bind seqchk_top seqchk_chk #(
  .DEPTH     (DEPTH),
  .MAX_LOOPS (MAX_LOOPS)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .ld_ready (ld_ready),
  .done     (done),
  .pass     (pass),
  .fail     (fail)
);

// File: tb/seqchk_tb.sv
module seqchk_top_tb_top;

  localparam int DEPTH  = 8;
  localparam int GOAL   = 3;
  localparam int LOOPS  = 6;
  localparam int IDX_W  = $clog2(DEPTH);
  localparam logic [63:0] POLY   = 64'h42F0E1EBA9EA3693;
  localparam logic [63:0] SEED_A = 64'h0123456789ABCDEF;
  localparam logic [63:0] SEED_B = 64'hF1E2D3C4B5A69788;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic             seed_sel = 1'b0;
  logic             ld_valid = 1'b0;
  logic             ld_ready;
  logic [IDX_W-1:0] ld_index = '0;
  logic [63:0]      ld_data = '0;
  logic             done, pass, fail;

  int n_chk = 0;
  int n_bad = 0;
  logic [63:0] shadow [DEPTH];

  always #10 clk = ~clk;

  seqchk_top #(
    .DEPTH (DEPTH), .WORD_W (64), .MATCH_GOAL (GOAL), .MAX_LOOPS (LOOPS),
    .POLY (POLY), .SEED_A (SEED_A), .SEED_B (SEED_B)
  ) dut_i (
    .clk (clk), .rst_n (rst_n), .start (start), .seed_sel (seed_sel),
    .ld_valid (ld_valid), .ld_ready (ld_ready), .ld_index (ld_index),
    .ld_data (ld_data), .done (done), .pass (pass), .fail (fail)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R3 step rule, computed independently
  function automatic logic [63:0] step(logic [63:0] x);
    logic [63:0] y = x << 1;
    if (x[63]) y = y ^ POLY;
    return y;
  endfunction

  function automatic logic [63:0] traj(logic [63:0] s, int k);
    logic [63:0] v = s;
    for (int i = 0; i < k; i++) v = step(v);
    return v;
  endfunction

  function automatic logic [63:0] seed_of(bit sel);
    return sel ? SEED_B : SEED_A;
  endfunction

  // model: R4 skip slot 0, R5 accumulate, R6/R7 decision
  function automatic void model(logic [63:0] s, output bit ok, output int passes);
    logic [63:0] c = s;
    int acc = 0;
    ok = 1'b0;
    passes = LOOPS;
    for (int l = 0; l < LOOPS; l++) begin
      for (int i = 1; i < DEPTH; i++) if (shadow[i] == c) acc++;
      if (acc >= GOAL) begin
        ok = 1'b1;
        passes = l + 1;
        return;
      end
      c = step(c);
    end
  endfunction

  task automatic load_buf(logic [63:0] w [DEPTH]);
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      ld_valid = 1'b1;
      ld_index = IDX_W'(i);
      ld_data  = w[i];
      shadow[i] = w[i];
    end
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  // run one check; poke drives a busy write and a busy start (R2, R9)
  task automatic run_case(string tag, bit sel, bit poke);
    bit ok;
    int exp_p;
    int cyc;
    model(seed_of(sel), ok, exp_p);
    @(negedge clk);
    seed_sel = sel;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    seed_sel = ~sel;
    cyc = 0;
    while (!done && cyc < 1000) begin
      if (poke && cyc == 1) begin
        ld_valid = 1'b1;
        ld_index = IDX_W'(1);
        ld_data  = seed_of(sel);
      end
      if (poke && cyc == 2) begin
        check({tag, " R2 ready low while busy"}, 64'(ld_ready), 64'd0);
        start = 1'b1;
      end
      if (poke && cyc == 3) begin
        start = 1'b0;
        ld_valid = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    check({tag, " R6 R7 latency"}, 64'(cyc), 64'(exp_p * (DEPTH - 1)));
    check({tag, " R6 pass"}, 64'(pass), 64'(ok));
    check({tag, " R7 fail"}, 64'(fail), 64'(!ok));
    check({tag, " R2 ready after done"}, 64'(ld_ready), 64'd1);
  endtask

  initial begin
    logic [63:0] w [DEPTH];
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1 done", 64'(done), 64'd0);
    check("R1 pass", 64'(pass), 64'd0);
    check("R1 fail", 64'(fail), 64'd0);
    check("R1 ready", 64'(ld_ready), 64'd1);
    rst_n = 1'b1;

    // R7: no trajectory words at all
    for (int i = 0; i < DEPTH; i++) w[i] = {$urandom, $urandom};
    load_buf(w);
    run_case("nohit", 1'b0, 1'b0);

    // R4 and R5: seed in slot 0 (ignored) plus two slots, one step value
    for (int i = 0; i < DEPTH; i++) w[i] = {$urandom, $urandom};
    w[0] = SEED_A; w[2] = SEED_A; w[5] = SEED_A; w[7] = step(SEED_A);
    load_buf(w);
    run_case("R4_skip0", 1'b0, 1'b0);

    // R9: result held, a write while done is taken without touching flags
    repeat (4) @(negedge clk);
    check("R9 hold done", 64'(done), 64'd1);
    check("R9 hold pass", 64'(pass), 64'd1);
    @(negedge clk);
    ld_valid = 1'b1; ld_index = IDX_W'(0); ld_data = 64'h0; shadow[0] = 64'h0;
    @(negedge clk);
    ld_valid = 1'b0;
    check("R9 hold after write", 64'(pass), 64'd1);

    // R8: seed B trajectory, same buffer under seed A must fail
    for (int i = 0; i < DEPTH; i++) w[i] = {$urandom, $urandom};
    w[1] = traj(SEED_B, 1); w[3] = traj(SEED_B, 3); w[6] = traj(SEED_B, 4);
    load_buf(w);
    run_case("R8_seedB", 1'b1, 1'b0);
    run_case("R8_seedA", 1'b0, 1'b0);

    // R6 boundary: goal reached on the final allowed pass
    for (int i = 0; i < DEPTH; i++) w[i] = {$urandom, $urandom};
    for (int i = 1; i <= GOAL; i++) w[i] = traj(SEED_A, LOOPS - 1);
    load_buf(w);
    run_case("R6_lastpass", 1'b0, 1'b0);
    // one short of the goal: R7
    w[1] = 64'h5;
    load_buf(w);
    run_case("R7_oneshort", 1'b0, 1'b0);
    // one step beyond the limit never counts
    for (int i = 1; i < DEPTH; i++) w[i] = traj(SEED_A, LOOPS);
    load_buf(w);
    run_case("R7_beyond", 1'b0, 1'b0);

    // R2, R9: write and start offered during a check are ignored
    for (int i = 0; i < DEPTH; i++) w[i] = {$urandom, $urandom};
    w[4] = traj(SEED_B, 2); w[5] = traj(SEED_B, 2); w[6] = traj(SEED_B, 5);
    load_buf(w);
    run_case("R2_busy", 1'b1, 1'b1);

    // R3 R5 R6 random mixes of trajectory and noise words
    for (int t = 0; t < 24; t++) begin
      bit sel = 1'($urandom % 2);
      for (int i = 0; i < DEPTH; i++) begin
        if ($urandom % 4 == 0) w[i] = {$urandom, $urandom};
        else w[i] = traj(seed_of(sel), int'($urandom % (LOOPS + 2)));
      end
      load_buf(w);
      run_case("R3_random", sel, 1'b0);
    end

    summary();
    $finish;
  end

endmodule